// File: doc/BRIEF.md
# Three-Wire Addressed Control Register Port

This block receives short configuration words over a three-wire serial link and holds the resulting control codes for a dual-channel filter: a voltage gain code, an octave (chord) select and a linear step select inside that octave, plus a test bit that turns on an internal oscillator. The link has a serial clock, a data line and an active-high enable. While the enable is high, each rising serial clock edge shifts one data bit into an 8-bit shift register, most significant bit first.

When the enable drops, the word is decoded. Bits 7..6 are an address and bits 5..0 are a payload. The payload goes into one of three 6-bit control registers, or into none. The falling enable is brought into the system clock domain through a two-flop synchroniser and an edge detector, so each window produces exactly one clean commit pulse. The 7-bit step code is assembled from two separately addressed registers. The control registers have no reset. Software has to write all three, usually with zero payloads, before the outputs mean anything. The system reset clears only the synchroniser.

All pins are plain control levels. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `tw_prog_port`

## Requirements
- R1: While `prog_en` is high, each rising edge of `prog_clk` shifts `prog_data` into the shift register, most significant bit first, so the first bit sent ends up in bit 7 after eight edges.
- R2: Rising edges of `prog_clk` while `prog_en` is low leave the shift register unchanged. This shows at the ports through the next commit.
- R3: A falling edge of `prog_en` gives exactly one commit. The outputs take their new value on the third rising edge of `clk` after the fall, counting from a fall that lies between clock edges. Nothing changes while `prog_en` stays at a constant level.
- R4: Address 00 writes the low frequency register. Payload bits 2..0 drive `octave_sel[2:0]` and payload bits 5..3 drive `step_sel[2:0]`.
- R5: Address 01 writes the high frequency register. Payload bit 5 drives `osc_test`, payload bit 4 is discarded, and payload bits 3..0 drive `step_sel[6:3]`.
- R6: Address 11 writes payload bits 5..0 to `gain_code[5:0]`.
- R7: A word with address 10 leaves all three control registers unchanged.
- R8: The commit decodes the current shift register contents. If more than eight bits arrive in one window, the last eight are used. If fewer arrive, the older bits shift up and fill the rest of the word.
- R9: Octave codes 5 to 7 are stored and output as written, and `octave_bad` is high exactly when `octave_sel` is 5 or more.
- R10: The control registers have no reset. Asserting `rst_n` does not change `gain_code`, `octave_sel`, `step_sel` or `osc_test`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for synchroniser and control registers |
| rst_n | input | 1 | Active-low reset of the synchroniser only |
| prog_clk | input | 1 | Serial clock, data sampled on its rising edge |
| prog_data | input | 1 | Serial data, most significant bit first |
| prog_en | input | 1 | Active-high window enable, commit on its fall |
| gain_code | output | 6 | Gain control code |
| octave_sel | output | 3 | Octave (chord) select |
| step_sel | output | 7 | Linear step select within the octave |
| osc_test | output | 1 | Oscillator test enable |
| octave_bad | output | 1 | High when the octave code is 5 or more |

## Verification
A shift register that slips by one bit, or that shifts outside the enable window, never fails on its own. It shows up as a wrong field value on the next commit, three system clock edges after the enable falls. A wrong address decode shows up in the same cycle as a change in a register that should not have been written. A fault in the synchroniser or edge detector shows up as an update one or more cycles early or late, or as a missing update. That is why the reference model is compared with the outputs on every clock, and not only once the link is idle.

// File: rtl/tw_prog_pkg.sv
`timescale 1ns/1ps
package tw_prog_pkg;
  parameter int WORD_W   = 8;
  parameter int ADDR_W   = 2;
  parameter int PAY_W    = WORD_W - ADDR_W;
  parameter int OCT_W    = 3;
  parameter int STEP_W   = 7;
  parameter int STEP_LO  = 3;
  parameter int STEP_HI  = STEP_W - STEP_LO;
  parameter int OCT_USED = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FREQ_LO = 2'b00,
    SEL_FREQ_HI = 2'b01,
    SEL_NONE    = 2'b10,
    SEL_GAIN    = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/tw_prog_shifter.sv
`timescale 1ns/1ps
module tw_prog_shifter #(
  parameter int W = 8
) (
  input  logic         sclk,
  input  logic         sen,
  input  logic         sdin,
  output logic [W-1:0] word
);
  logic [W-1:0] sr_q;

  // No reset: contents are defined only by what has been shifted in.
  always_ff @(posedge sclk) begin
    if (sen) sr_q <= {sr_q[W-2:0], sdin};
  end

  assign word = sr_q;
endmodule

// File: rtl/tw_prog_commit_sync.sv
`timescale 1ns/1ps
module tw_prog_commit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic commit
);
  localparam int LAST = STAGES;
  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], en_async};
  end

  // A fall is seen when the delayed copy is high and the synchronised level is low.
  assign commit = chain_q[LAST] & ~chain_q[LAST-1];

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/tw_prog_regs.sv
`timescale 1ns/1ps
module tw_prog_regs
  import tw_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [PAY_W-1:0]  gain,
  output logic [OCT_W-1:0]  octave,
  output logic [STEP_W-1:0] step,
  output logic              osc
);
  logic [PAY_W-1:0]   gain_q;
  logic [OCT_W-1:0]   oct_q;
  logic [STEP_LO-1:0] slo_q;
  logic [STEP_HI-1:0] shi_q;
  logic               osc_q;
  reg_sel_e           sel;
  logic [PAY_W-1:0]   pay;

  assign sel = reg_sel_e'(word[WORD_W-1 -: ADDR_W]);
  assign pay = word[PAY_W-1:0];

  // Control registers deliberately carry no reset.
  always_ff @(posedge clk) begin
    if (commit) begin
      unique case (sel)
        SEL_FREQ_LO: begin
          oct_q <= pay[OCT_W-1:0];
          slo_q <= pay[PAY_W-1 -: STEP_LO];
        end
        SEL_FREQ_HI: begin
          osc_q <= pay[PAY_W-1];
          shi_q <= pay[STEP_HI-1:0];
        end
        SEL_GAIN: gain_q <= pay;
        default: ;
      endcase
    end
  end

  assign gain   = gain_q;
  assign octave = oct_q;
  assign step   = {shi_q, slo_q};
  assign osc    = osc_q;

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(gain) && $stable(octave) && $stable(step) && $stable(osc)));
  a_r6_gain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[WORD_W-1 -: ADDR_W] == 2'b11) |=> gain == $past(word[PAY_W-1:0]));
  a_r7_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[WORD_W-1 -: ADDR_W] == 2'b10) |=>
      ($stable(gain) && $stable(octave) && $stable(step) && $stable(osc)));
  a_r5_osc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[WORD_W-1 -: ADDR_W] == 2'b01) |=> osc == $past(word[PAY_W-1]));
endmodule

// File: rtl/tw_prog_port.sv
`timescale 1ns/1ps
module tw_prog_port
  import tw_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_clk,
  input  logic              prog_data,
  input  logic              prog_en,
  output logic [PAY_W-1:0]  gain_code,
  output logic [OCT_W-1:0]  octave_sel,
  output logic [STEP_W-1:0] step_sel,
  output logic              osc_test,
  output logic              octave_bad
);
  logic [WORD_W-1:0] sr_word;
  logic              commit;

  tw_prog_shifter #(.W(WORD_W)) u_shift (
    .sclk(prog_clk), .sen(prog_en), .sdin(prog_data), .word(sr_word)
  );

  tw_prog_commit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_async(prog_en), .commit(commit)
  );

  tw_prog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(sr_word),
    .gain(gain_code), .octave(octave_sel), .step(step_sel), .osc(osc_test)
  );

  assign octave_bad = (int'(octave_sel) >= OCT_USED);
endmodule

// File: tb/tw_prog_port_bench.sv
`timescale 1ns/1ps
module tw_prog_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_clk = 1'b0, prog_data = 1'b0, prog_en = 1'b0;
  logic [5:0] gain_code;
  logic [2:0] octave_sel;
  logic [6:0] step_sel;
  logic osc_test, octave_bad;

  int tests = 0, fails = 0;
  int m_sr = 0, pend = 0, pend_word = 0;
  int e_gain = 0, e_oct = 0, e_slo = 0, e_shi = 0, e_osc = 0;
  bit k_a = 0, k_b = 0, k_g = 0, done = 0;

  always #2.5 clk = ~clk;

  tw_prog_port u_tw_prog_port (
    .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_data(prog_data),
    .prog_en(prog_en), .gain_code(gain_code), .octave_sel(octave_sel),
    .step_sel(step_sel), .osc_test(osc_test), .octave_bad(octave_bad)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_word(input int w);
    case ((w >> 6) & 3)
      0: begin e_oct = w & 7; e_slo = (w >> 3) & 7; k_a = 1; end
      1: begin e_osc = (w >> 5) & 1; e_shi = w & 15; k_b = 1; end
      3: begin e_gain = w & 63; k_g = 1; end
      default: ;
    endcase
  endtask

  // Reference model: commit lands on the third rising clock edge after the fall.
  always @(posedge clk) begin
    if (pend > 0) begin
      pend--;
      if (pend == 0) apply_word(pend_word);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (k_g) chk(gain_code == e_gain[5:0], "R6 model gain", gain_code, e_gain);
      if (k_a) begin
        chk(octave_sel == e_oct[2:0], "R4 model octave", octave_sel, e_oct);
        chk(step_sel[2:0] == e_slo[2:0], "R4 model step lo", step_sel[2:0], e_slo);
        chk(octave_bad == (e_oct >= 5), "R9 model flag", octave_bad, e_oct >= 5);
      end
      if (k_b) begin
        chk(step_sel[6:3] == e_shi[3:0], "R5 model step hi", step_sel[6:3], e_shi);
        chk(osc_test == e_osc[0], "R5 model osc", osc_test, e_osc);
      end
    end
  end

  task automatic send(input int n, input int bits);
    @(negedge clk) prog_en = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      prog_data = bits[i];
      @(negedge clk) prog_clk = 1'b1;
      m_sr = ((m_sr << 1) | bits[i]) & 255;
      @(negedge clk);
      @(negedge clk) prog_clk = 1'b0;
      @(negedge clk);
    end
    @(negedge clk) prog_en = 1'b0;
    pend = 3;
    pend_word = m_sr;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [5:0] g0; logic [2:0] o0; logic [6:0] s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    g0 = gain_code; o0 = octave_sel; s0 = step_sel;
    repeat (10) @(negedge clk);
    chk(gain_code == g0 && octave_sel == o0 && step_sel == s0, "R3 no commit after reset",
        gain_code, g0);

    // Reset words.
    send(8, 8'b00_000000); settle();
    send(8, 8'b01_000000); settle();
    send(8, 8'b11_000000); settle();
    chk(octave_sel == 0, "R4 clear octave", octave_sel, 0);
    chk(step_sel == 0, "R5 clear step", step_sel, 0);
    chk(gain_code == 0, "R6 clear gain", gain_code, 0);

    // R1 order and R4/R5 field placement.
    send(8, 8'b00_101_011); settle();
    send(8, 8'b01_1_0_1100); settle();
    chk(octave_sel == 3, "R1 R4 octave", octave_sel, 3);
    chk(step_sel == 7'b1100101, "R4 R5 step", step_sel, 7'b1100101);
    chk(osc_test == 1, "R5 osc", osc_test, 1);
    send(8, 8'b01_0_1_0011); settle();
    chk(step_sel == 7'b0011101, "R5 bit4 discarded", step_sel, 7'b0011101);
    chk(osc_test == 0, "R5 osc off", osc_test, 0);

    // R3 exact timing of a gain write.
    send(8, 8'b11_011001);
    @(posedge clk); @(posedge clk); #1;
    chk(gain_code == 0, "R3 not yet", gain_code, 0);
    @(posedge clk); #1;
    chk(gain_code == 25, "R3 R6 third edge", gain_code, 25);
    settle();

    // R7 unused address.
    send(8, 8'b10_111111); settle();
    chk(gain_code == 25 && octave_sel == 3 && step_sel == 7'b0011101,
        "R7 addr 10 ignored", gain_code, 25);

    // R9 out-of-range octaves.
    send(8, 8'b00_010_111); settle();
    chk(octave_sel == 7 && octave_bad, "R9 octave 7", octave_sel, 7);
    send(8, 8'b00_010_100); settle();
    chk(octave_sel == 4 && !octave_bad, "R9 octave 4", octave_sel, 4);

    // R8 long and short windows.
    send(10, 10'b10_11_100001); settle();
    chk(gain_code == 33, "R8 last eight", gain_code, 33);
    send(3, 3'b101); settle();
    chk(octave_sel == 5 && octave_bad, "R8 short window octave", octave_sel, 5);
    chk(step_sel[2:0] == 3'b001, "R8 short window step", step_sel[2:0], 1);

    // R2 serial clock ignored with enable low.
    prog_data = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) prog_clk = 1'b1;
      @(negedge clk) prog_clk = 1'b0;
    end
    send(0, 0); settle();
    chk(gain_code == 33, "R2 gain untouched", gain_code, 33);
    chk(octave_sel == 5, "R2 octave recommitted", octave_sel, 5);

    // R10 reset leaves control registers.
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk(gain_code == 33 && octave_sel == 5, "R10 reset keeps gain/octave", gain_code, 33);
    chk(step_sel == 7'b0011001, "R10 reset keeps step", step_sel, 7'b0011001);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule